// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer behind a small register port with three registers: control/status, counter/command and timeout. Software cannot change the configuration, and cannot service the watchdog, by setting a single bit. Each of these actions needs a magic value written to the counter/command register. An unlock key opens a short window in which the control/status and timeout registers accept writes. A refresh key returns the running count to zero. The key words can be given in two ways. In half-word mode each key is two consecutive writes of 16-bit halves. In word mode each key is one 32-bit write.

A slow tick input advances the counter while the watchdog is enabled. When the count reaches the programmed timeout, the block raises a one-cycle reset request. It raises the same request when a key sequence is broken halfway while the watchdog is enabled. Software can also clear the update-permit bit during a reconfiguration. That freezes the configuration until the next hardware reset.

Top module: `keywdt`

## Requirements
- R1: After reset, control/status reads 0x0000_0020 (only update-permit set). The counter reads 0, the timeout reads the RST_TOVAL parameter, and `rst_req` is low. Offsets are control/status 0x0, counter/command 0x4 and timeout 0x8. Any other offset reads 0.
- R2: With bit 13 of control/status clear (half-word mode), a write of 0xC520 and then a write of 0xD928 to offset 0x4 unlock the block. Only bits 15:0 of each write are compared. The unlocked status reads on bit 11. The timeout register takes writes only while unlocked.
- R3: With bit 13 set (word mode), the word 0xD928C520 unlocks and the word 0xB480A602 refreshes. Half-word keys and any other value written to 0x4 have no effect.
- R4: The unlock lasts 128 clock cycles counted from the unlocking write (parameter WIN). After that bit 11 clears and configuration writes are ignored.
- R5: A control/status write is taken only while unlocked. It loads bit 13 (word mode), bits 9:8 (clock select), bit 7 (enable) and bit 5 (update permit). It also sets bit 10 (reconfigured) and ends the unlock at once. A write while locked changes nothing.
- R6: In half-word mode, 0xA602 followed by 0xB480 at offset 0x4 clears the counter.
- R7: While enabled, each cycle with `tick` high adds one to the counter. While disabled, the counter is held at 0.
- R8: While enabled, a count at or above the timeout value makes `rst_req` high for exactly the next cycle and clears the counter. This has priority over refresh and tick.
- R9: In half-word mode, a wrong second half after a first half (either key) makes `rst_req` high for one cycle if enabled. If disabled it has no effect. Either way the sequence is dropped.
- R10: Once a reconfiguration has left bit 5 clear, unlock keys are ignored until reset. Reset restores unlocking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse from the slow time base |
| wr | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `wr` is a single-cycle strobe with a stable `addr`. They also assume that the timeout register is changed only through the register port. Under these assumptions an enable or timeout change can always be traced back to an unlocked write one cycle earlier. The random phase therefore issues only legal counter/command writes in word mode: refresh words, and junk words whose top nibble can never match a key. The directed phase covers the broken sequences, the window edge and the lockout, where the reset-request assertions must still hold.

// File: rtl/keywdt.sv
module keywdt #(
  parameter int CNT_W = 32,
  parameter int WIN = 128,
  parameter logic [CNT_W-1:0] RST_TOVAL = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rst_req
);
  localparam int WIN_W = $clog2(WIN + 1);
  localparam logic [3:0] A_CS = 4'h0, A_CNT = 4'h4, A_TO = 4'h8;
  localparam logic [15:0] UNL_LO = 16'hC520, UNL_HI = 16'hD928;
  localparam logic [15:0] REF_LO = 16'hA602, REF_HI = 16'hB480;

  typedef enum logic [1:0] {P_IDLE, P_UNL, P_REF} pend_t;

  logic             cmd32, en, upd, cfg_done;
  logic [1:0]       csel;
  logic [CNT_W-1:0] toval, cnt;
  logic [WIN_W-1:0] win;
  pend_t            pend, pend_nx;
  logic             do_unl, do_ref, bad;

  wire unl     = (win != '0);
  wire lockout = cfg_done & ~upd;
  wire wr_cs   = wr && addr == A_CS;
  wire wr_cnt  = wr && addr == A_CNT;
  wire wr_to   = wr && addr == A_TO;
  wire [15:0] half = wdata[15:0];
  wire hit = en && (cnt >= toval);

  always_comb begin
    do_unl  = 1'b0;
    do_ref  = 1'b0;
    bad     = 1'b0;
    pend_nx = pend;
    if (wr_cnt) begin
      pend_nx = P_IDLE;
      if (cmd32) begin
        do_unl = (wdata == {UNL_HI, UNL_LO});
        do_ref = (wdata == {REF_HI, REF_LO});
      end else begin
        case (pend)
          P_UNL: if (half == UNL_HI) do_unl = 1'b1; else bad = 1'b1;
          P_REF: if (half == REF_HI) do_ref = 1'b1; else bad = 1'b1;
          default:
            if (half == UNL_LO) pend_nx = P_UNL;
            else if (half == REF_LO) pend_nx = P_REF;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd32    <= 1'b0;
      en       <= 1'b0;
      upd      <= 1'b1;
      cfg_done <= 1'b0;
      csel     <= 2'b00;
      toval    <= RST_TOVAL;
      cnt      <= '0;
      win      <= '0;
      pend     <= P_IDLE;
      rst_req  <= 1'b0;
    end else begin
      pend    <= wr_cs ? P_IDLE : pend_nx;
      rst_req <= hit || (en && bad);
      if (wr_cs && unl) begin
        cmd32    <= wdata[13];
        csel     <= wdata[9:8];
        en       <= wdata[7];
        upd      <= wdata[5];
        cfg_done <= 1'b1;
        win      <= '0;
      end else if (do_unl && !lockout) begin
        win <= WIN_W'(WIN);
      end else if (unl) begin
        win <= win - 1'b1;
      end
      if (wr_to && unl) toval <= wdata[CNT_W-1:0];
      if (!en || hit || do_ref) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CS:    rdata = {18'b0, cmd32, 1'b0, unl, cfg_done, csel, en, 1'b0, upd, 5'b0};
      A_CNT:   rdata = 32'(cnt);
      A_TO:    rdata = 32'(toval);
      default: rdata = 32'h0;
    endcase
  end
endmodule

module keywdt_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr,
  input logic [3:0]   addr,
  input logic         rst_req,
  input logic         en,
  input logic         unl,
  input logic         lockout,
  input logic [W-1:0] cnt,
  input logic [W-1:0] toval
);
  // R8
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(en));
  // R7
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
  // R4
  unlock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl) |-> $past(wr && addr == 4'h4));
  // R5
  enable_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en) |-> $past(unl && wr && addr == 4'h0));
  // R2
  toval_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(toval) |-> $past(unl && wr && addr == 4'h8));
  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> !unl);
endmodule

bind keywdt keywdt_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .rst_req(rst_req),
  .en(en), .unl(unl), .lockout(lockout), .cnt(cnt), .toval(toval)
);

// File: tb/keywdt_bench.sv
`timescale 1ns/100ps
module keywdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        rst_req;
  int checks = 0;
  int errors = 0;
  logic [31:0] v;
  logic [31:0] mcnt;
  logic        mreq;

  always #2.5 clk = ~clk;

  keywdt u_keywdt (.clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .rst_req(rst_req));

  function automatic logic [31:0] cs_val(logic w32, logic u, logic d, logic e, logic p);
    return {18'b0, w32, 1'b0, u, d, 2'b00, e, 1'b0, p, 5'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic unlock16();
    wreg(4'h4, 32'h0000C520);
    wreg(4'h4, 32'h0000D928);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] model_step(logic [31:0] c, logic [31:0] to,
                                             logic rf, logic tk, output logic fire);
    fire = (c >= to);
    if (fire || rf) return 32'h0;
    return tk ? c + 1 : c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    do_reset();
    rd(4'h0, v); chk("R1 cs", v, 32'h20);
    rd(4'h4, v); chk("R1 cnt", v, 0);
    rd(4'h8, v); chk("R1 toval", v, 1000);
    rd(4'hC, v); chk("R1 hole", v, 0);
    chk("R1 rst_req", {31'b0, rst_req}, 0);

    wreg(4'h8, 32'd5);
    rd(4'h8, v); chk("R2 locked toval", v, 1000);
    wreg(4'h0, 32'hA0);
    rd(4'h0, v); chk("R5 locked cs", v, 32'h20);

    unlock16();
    rd(4'h0, v); chk("R2 unlocked", v, cs_val(0, 1, 0, 0, 1));
    wreg(4'h8, 32'd5);
    rd(4'h8, v); chk("R2 toval", v, 5);
    wreg(4'h0, 32'hA0);
    rd(4'h0, v); chk("R5 enable", v, cs_val(0, 0, 1, 1, 1));

    ticks(3);
    rd(4'h4, v); chk("R7 count", v, 3);
    wreg(4'h4, 32'h0000A602);
    wreg(4'h4, 32'h0000B480);
    rd(4'h4, v); chk("R6 refresh", v, 0);

    ticks(5);
    rd(4'h4, v); chk("R8 at limit", v, 5);
    chk("R8 before", {31'b0, rst_req}, 0);
    @(negedge clk);
    chk("R8 fire", {31'b0, rst_req}, 1);
    rd(4'h4, v); chk("R8 cleared", v, 0);
    @(negedge clk);
    chk("R8 one cycle", {31'b0, rst_req}, 0);

    wreg(4'h4, 32'h0000A602);
    wreg(4'h4, 32'h00001234);
    chk("R9 bad half", {31'b0, rst_req}, 1);
    @(negedge clk);
    chk("R9 one cycle", {31'b0, rst_req}, 0);

    unlock16();
    wreg(4'h0, 32'h20);
    wreg(4'h4, 32'h0000C520);
    wreg(4'h4, 32'h00001234);
    chk("R9 disabled", {31'b0, rst_req}, 0);
    ticks(2);
    rd(4'h4, v); chk("R7 disabled", v, 0);

    unlock16();
    repeat (127) @(negedge clk);
    rd(4'h0, v); chk("R4 last cycle", v & 32'h800, 32'h800);
    @(negedge clk);
    rd(4'h0, v); chk("R4 expired", v & 32'h800, 0);
    wreg(4'h8, 32'd77);
    rd(4'h8, v); chk("R4 late write", v, 5);

    unlock16();
    wreg(4'h8, 32'd50);
    wreg(4'h0, 32'h20A0);
    rd(4'h0, v); chk("R5 word mode", v, cs_val(1, 0, 1, 1, 1));
    unlock16();
    rd(4'h0, v); chk("R3 halves ignored", v & 32'h800, 0);
    chk("R3 no fault", {31'b0, rst_req}, 0);
    wreg(4'h4, 32'hD928C520);
    rd(4'h0, v); chk("R3 word unlock", v & 32'h800, 32'h800);
    wreg(4'h0, 32'h20A0);

    mcnt = 0;
    rd(4'h4, v); chk("R3 start", v, 0);
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic tk, rf;
      r = $urandom % 64;
      tk = $urandom % 2;
      rf = (r == 0);
      tick = tk;
      if (r < 2) begin
        wr = 1'b1; addr = 4'h4;
        wdata = rf ? 32'hB480A602 : ($urandom & 32'h0FFF_FFFF);
      end
      @(posedge clk);
      mcnt = model_step(mcnt, 50, rf, tk, mreq);
      @(negedge clk);
      wr = 1'b0; tick = 1'b0;
      rd(4'h4, v); chk("R8 random count", v, mcnt);
      chk("R8 random req", {31'b0, rst_req}, {31'b0, mreq});
    end

    wreg(4'h4, 32'hB480A602);
    rd(4'h4, v); chk("R3 word refresh", v, 0);
    wreg(4'h4, 32'hD928C520);
    wreg(4'h0, 32'h2080);
    rd(4'h0, v); chk("R10 frozen cfg", v, cs_val(1, 0, 1, 1, 0));
    wreg(4'h4, 32'hD928C520);
    rd(4'h0, v); chk("R10 unlock ignored", v & 32'h800, 0);
    wreg(4'h8, 32'd9);
    rd(4'h8, v); chk("R10 toval kept", v, 50);

    do_reset();
    rd(4'h0, v); chk("R10 reset clears", v, 32'h20);
    unlock16();
    rd(4'h0, v); chk("R10 unlock again", v & 32'h800, 32'h800);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule